// File: doc/BRIEF.md
# Stored-Register Write and Recall Sequencer

This block keeps the stored setting registers of a bank of digitally controlled potentiometers. It holds several byte-wide slots for every pot and writes into them on three kinds of command: a byte supplied by the host, the present wiper of one pot, or the present wipers of all pots at once. Each write models a slow nonvolatile programming cycle, which is counted in external time-base ticks, and a busy flag stays high while it runs. It also loads wipers from the slots: one pot or all pots on command, and slot 0 of every pot automatically when reset is released.

A serial front end decodes bus traffic into single-cycle command pulses. It raises `stop_i` when the bus transfer that carried a store command ends, and programming starts only then. A low level on the protect pin discards store commands, and any command that arrives while a store is pending or running is dropped. Slot contents are not cleared by reset, so a recall after a reset returns what was last stored.

Top module: `nvs_store_seq`

## Requirements
- R1: On the first clock edge after reset is released, `wiper_load_o` pulses all ones for one cycle, and each lane p of `wiper_val_o` (bits p*DW upward) carries slot 0 of pot p. No strobe appears at any other time without a recall command.
- R2: Op code 1 (write byte) stores `wdata_i` into the slot `slot_sel_i` of pot `pot_sel_i`. The new value shows on `rd_data_o`, which always reads that same slot and pot combinationally.
- R3: Op code 2 (store one) stores wiper lane `pot_sel_i` of `wiper_i` into slot `slot_sel_i` of that pot and leaves every other pot unchanged.
- R4: Op code 3 (store all) stores each wiper lane p into slot `slot_sel_i` of pot p. The wiper values are those present in the cycle the command is accepted.
- R5: Op code 4 (recall one) gives, one cycle after acceptance, a one-hot `wiper_load_o` at bit `pot_sel_i`, with lane `pot_sel_i` of `wiper_val_o` holding that pot's slot `slot_sel_i`.
- R6: Op code 5 (recall all) gives, one cycle after acceptance, `wiper_load_o` all ones, with every lane p holding slot `slot_sel_i` of pot p.
- R7: An accepted store changes no slot and leaves `busy_o` low until `stop_i` is seen. On the edge that samples `stop_i`, the slot is written and `busy_o` rises.
- R8: After a store starts, `busy_o` stays high until exactly BUSY_TICKS clock edges have sampled `tick_i` high, and it falls on the last of them.
- R9: While `wp_n_i` is low, store commands (op codes 1 to 3) are discarded: no slot changes and `busy_o` stays low, even after `stop_i`.
- R10: Any command that arrives while a store is pending or `busy_o` is high is discarded. It changes no slot and produces no wiper strobe.
- R11: Slot contents are kept across reset, and the recall at reset release returns the values stored before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (slot contents are kept) |
| cmd_valid_i | input | 1 | Single-cycle command pulse |
| cmd_op_i | input | 3 | Op code: 1 write byte, 2 store one, 3 store all, 4 recall one, 5 recall all |
| pot_sel_i | input | $clog2(NPOT) | Pot select; also the read address |
| slot_sel_i | input | $clog2(NSLOT) | Slot select; also the read address |
| wdata_i | input | DW | Byte for op code 1 |
| wiper_i | input | NPOT*DW | Present wiper values, lane p for pot p |
| wp_n_i | input | 1 | Store enable; low blocks stores |
| stop_i | input | 1 | End of the bus transfer; starts a pending store |
| tick_i | input | 1 | Time-base pulse that counts down the busy period |
| rd_data_o | output | DW | Contents of the addressed slot |
| busy_o | output | 1 | Programming in progress (also high in the cycle after reset) |
| wiper_load_o | output | NPOT | Per-pot wiper load strobe |
| wiper_val_o | output | NPOT*DW | Values for the strobed wipers |

## Verification
The bench builds the block with BUSY_TICKS = 6, which makes every step of the programming countdown observable, including the exact tick on which `busy_o` falls. It uses an initial slot value of 8'h3C, so untouched slots are easy to tell apart from written ones and from zero. The default of four pots and four slots lets one bench cover single-pot writes and all-pot stores and recalls. It also covers the rejection of commands arriving during the pending and busy windows, and a second reset that proves stored values persist.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef enum logic [2:0] {
      OP_NOP        = 3'd0,
      OP_WRITE      = 3'd1,
      OP_STORE_ONE  = 3'd2,
      OP_STORE_ALL  = 3'd3,
      OP_RECALL_ONE = 3'd4,
      OP_RECALL_ALL = 3'd5
   } nvs_op_e;

   typedef enum logic [1:0] {
      ST_BOOT,
      ST_IDLE,
      ST_ARMED,
      ST_BUSY
   } nvs_state_e;

endpackage

// File: rtl/nvs_slot_bank.sv
module nvs_slot_bank #(
   parameter int NPOT = 4,
   parameter int NSLOT = 4,
   parameter int DW = 8,
   parameter logic [DW-1:0] INIT_BYTE = '0,
   localparam int PW = $clog2(NPOT),
   localparam int SW = $clog2(NSLOT)
) (
   input  logic               clk,
   input  logic [NPOT-1:0]    we_mask_i,
   input  logic [SW-1:0]      we_slot_i,
   input  logic [NPOT*DW-1:0] we_bytes_i,
   input  logic [SW-1:0]      row_slot_i,
   output logic [NPOT*DW-1:0] row_o,
   input  logic [PW-1:0]      rd_pot_i,
   input  logic [SW-1:0]      rd_slot_i,
   output logic [DW-1:0]      rd_data_o
);

   logic [NPOT*DW-1:0] rd_row;

   for (genvar p = 0; p < NPOT; p++) begin : g_pot
      logic [DW-1:0] cells [NSLOT];

      initial begin
         for (int s = 0; s < NSLOT; s++) cells[s] = INIT_BYTE;
      end

      always_ff @(posedge clk) begin
         if (we_mask_i[p]) cells[we_slot_i] <= we_bytes_i[p*DW +: DW];
      end

      assign row_o[p*DW +: DW]  = cells[row_slot_i];
      assign rd_row[p*DW +: DW] = cells[rd_slot_i];
   end

   assign rd_data_o = rd_row[rd_pot_i*DW +: DW];

endmodule

// File: rtl/nvs_seq_ctrl.sv
module nvs_seq_ctrl
   import nvs_pkg::*;
#(
   parameter int NPOT = 4,
   parameter int NSLOT = 4,
   parameter int DW = 8,
   parameter int BUSY_TICKS = 5000,
   localparam int PW = $clog2(NPOT),
   localparam int SW = $clog2(NSLOT),
   localparam int CW = $clog2(BUSY_TICKS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid_i,
   input  logic [2:0]         cmd_op_i,
   input  logic [PW-1:0]      pot_i,
   input  logic [SW-1:0]      slot_i,
   input  logic [DW-1:0]      wdata_i,
   input  logic [NPOT*DW-1:0] wiper_i,
   input  logic               wp_n_i,
   input  logic               stop_i,
   input  logic               tick_i,
   input  logic [NPOT*DW-1:0] row_i,
   output logic [SW-1:0]      row_slot_o,
   output logic [NPOT-1:0]    we_mask_o,
   output logic [SW-1:0]      we_slot_o,
   output logic [NPOT*DW-1:0] we_bytes_o,
   output logic               busy_o,
   output logic [NPOT-1:0]    load_o,
   output logic [NPOT*DW-1:0] val_o
);

   nvs_state_e         st;
   nvs_op_e            op;
   logic [CW-1:0]      cnt;
   logic [NPOT-1:0]    mask_q;
   logic [SW-1:0]      slot_q;
   logic [NPOT*DW-1:0] bytes_q;
   logic [NPOT-1:0]    load_q;
   logic [NPOT*DW-1:0] val_q;
   logic [NPOT-1:0]    pot_hot;
   logic               is_store;
   logic               is_recall;

   assign op        = nvs_op_e'(cmd_op_i);
   assign is_store  = (op == OP_WRITE) || (op == OP_STORE_ONE) || (op == OP_STORE_ALL);
   assign is_recall = (op == OP_RECALL_ONE) || (op == OP_RECALL_ALL);
   assign pot_hot   = {{(NPOT-1){1'b0}}, 1'b1} << pot_i;

   assign row_slot_o = (st == ST_BOOT) ? '0 : slot_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_BOOT;
         cnt     <= '0;
         mask_q  <= '0;
         slot_q  <= '0;
         bytes_q <= '0;
         load_q  <= '0;
         val_q   <= '0;
      end else begin
         load_q <= '0;
         unique case (st)
            ST_BOOT: begin
               load_q <= '1;
               val_q  <= row_i;
               st     <= ST_IDLE;
            end
            ST_IDLE: begin
               if (cmd_valid_i && is_store && wp_n_i) begin
                  mask_q  <= (op == OP_STORE_ALL) ? '1 : pot_hot;
                  slot_q  <= slot_i;
                  bytes_q <= (op == OP_WRITE) ? {NPOT{wdata_i}} : wiper_i;
                  st      <= ST_ARMED;
               end else if (cmd_valid_i && is_recall) begin
                  load_q <= (op == OP_RECALL_ALL) ? '1 : pot_hot;
                  val_q  <= row_i;
               end
            end
            ST_ARMED: begin
               if (stop_i) begin
                  cnt <= CW'(BUSY_TICKS);
                  st  <= ST_BUSY;
               end
            end
            ST_BUSY: begin
               if (tick_i) begin
                  if (cnt == CW'(1)) st <= ST_IDLE;
                  cnt <= cnt - CW'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign we_mask_o  = (st == ST_ARMED && stop_i) ? mask_q : '0;
   assign we_slot_o  = slot_q;
   assign we_bytes_o = bytes_q;
   assign busy_o     = (st == ST_BOOT) || (st == ST_BUSY);
   assign load_o     = load_q;
   assign val_o      = val_q;

   // R1: reset release recalls every pot
   assert_boot_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BOOT) |=> (load_q == '1));

   // R7: programming only starts from a sampled stop
   assert_commit_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_BUSY) |-> $past(stop_i));

   // R8: the countdown never idles at zero while busy
   assert_timer_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BUSY) |-> (cnt != '0));

   // R9: protected store leaves the controller idle
   assert_protect_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && cmd_valid_i && is_store && !wp_n_i) |=> (st == ST_IDLE));

   // R10: no wiper strobe follows a pending or running store
   assert_no_load_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ARMED || st == ST_BUSY) |=> (load_q == '0));

endmodule

// File: rtl/nvs_store_seq.sv
module nvs_store_seq #(
   parameter int NPOT = 4,
   parameter int NSLOT = 4,
   parameter int DW = 8,
   parameter int BUSY_TICKS = 5000,
   parameter logic [DW-1:0] INIT_BYTE = 8'h80,
   localparam int PW = $clog2(NPOT),
   localparam int SW = $clog2(NSLOT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid_i,
   input  logic [2:0]         cmd_op_i,
   input  logic [PW-1:0]      pot_sel_i,
   input  logic [SW-1:0]      slot_sel_i,
   input  logic [DW-1:0]      wdata_i,
   input  logic [NPOT*DW-1:0] wiper_i,
   input  logic               wp_n_i,
   input  logic               stop_i,
   input  logic               tick_i,
   output logic [DW-1:0]      rd_data_o,
   output logic               busy_o,
   output logic [NPOT-1:0]    wiper_load_o,
   output logic [NPOT*DW-1:0] wiper_val_o
);

   if (NPOT < 2 || NSLOT < 2 || DW < 1 || BUSY_TICKS < 1) begin : g_param_check
      $error("nvs_store_seq: NPOT and NSLOT need at least 2, DW and BUSY_TICKS at least 1");
   end

   logic [SW-1:0]      row_slot;
   logic [NPOT*DW-1:0] row;
   logic [NPOT-1:0]    we_mask;
   logic [SW-1:0]      we_slot;
   logic [NPOT*DW-1:0] we_bytes;

   nvs_seq_ctrl #(
      .NPOT(NPOT), .NSLOT(NSLOT), .DW(DW), .BUSY_TICKS(BUSY_TICKS)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid_i (cmd_valid_i),
      .cmd_op_i    (cmd_op_i),
      .pot_i       (pot_sel_i),
      .slot_i      (slot_sel_i),
      .wdata_i     (wdata_i),
      .wiper_i     (wiper_i),
      .wp_n_i      (wp_n_i),
      .stop_i      (stop_i),
      .tick_i      (tick_i),
      .row_i       (row),
      .row_slot_o  (row_slot),
      .we_mask_o   (we_mask),
      .we_slot_o   (we_slot),
      .we_bytes_o  (we_bytes),
      .busy_o      (busy_o),
      .load_o      (wiper_load_o),
      .val_o       (wiper_val_o)
   );

   nvs_slot_bank #(
      .NPOT(NPOT), .NSLOT(NSLOT), .DW(DW), .INIT_BYTE(INIT_BYTE)
   ) i_bank (
      .clk        (clk),
      .we_mask_i  (we_mask),
      .we_slot_i  (we_slot),
      .we_bytes_i (we_bytes),
      .row_slot_i (row_slot),
      .row_o      (row),
      .rd_pot_i   (pot_sel_i),
      .rd_slot_i  (slot_sel_i),
      .rd_data_o  (rd_data_o)
   );

endmodule

// File: tb/test_nvs_store_seq.sv
`timescale 1ns/1ps
module test_nvs_store_seq;

   localparam int NP = 4;
   localparam int NS = 4;
   localparam int DW = 8;
   localparam int BT = 6;
   localparam logic [7:0] INIT = 8'h3C;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cmd_valid = 1'b0;
   logic [2:0]     cmd_op = 3'd0;
   logic [1:0]     pot_sel = '0;
   logic [1:0]     slot_sel = '0;
   logic [7:0]     wdata = '0;
   logic [31:0]    wiper = '0;
   logic           wp_n = 1'b1;
   logic           stop = 1'b0;
   logic           tick = 1'b0;
   logic [7:0]     rd_data;
   logic           busy;
   logic [3:0]     wiper_load;
   logic [31:0]    wiper_val;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0]  m [NP][NS];
   logic [35:0] q [$];

   always #10 clk = ~clk;

   nvs_store_seq #(.NPOT(NP), .NSLOT(NS), .DW(DW), .BUSY_TICKS(BT), .INIT_BYTE(INIT)) i_nvs_store_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
      .pot_sel_i(pot_sel), .slot_sel_i(slot_sel), .wdata_i(wdata), .wiper_i(wiper),
      .wp_n_i(wp_n), .stop_i(stop), .tick_i(tick), .rd_data_o(rd_data), .busy_o(busy),
      .wiper_load_o(wiper_load), .wiper_val_o(wiper_val)
   );

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] row(input int s);
      return {m[3][s], m[2][s], m[1][s], m[0][s]};
   endfunction

   // monitor: every wiper strobe must match the oldest expected item
   always @(negedge clk) begin
      if (rst_n && wiper_load != '0) begin
         if (q.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 unexpected strobe actual=%h expected=none", {wiper_load, wiper_val});
         end else begin
            logic [35:0] e;
            e = q.pop_front();
            chk("R1/R5/R6 wiper strobe", {wiper_load, wiper_val}, e);
         end
      end
   end

   task automatic issue(input logic [2:0] op, input int pot, input int slot, input logic [7:0] d);
      cmd_op = op; pot_sel = 2'(pot); slot_sel = 2'(slot); wdata = d;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic pulse_stop();
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
   endtask

   task automatic tick1();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic drain();
      repeat (BT) tick1();
   endtask

   task automatic rd_chk(input string tag, input int pot, input int slot);
      pot_sel = 2'(pot); slot_sel = 2'(slot);
      #1;
      chk(tag, 36'(rd_data), 36'(m[pot][slot]));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int p = 0; p < NP; p++)
         for (int s = 0; s < NS; s++) m[p][s] = INIT;

      // R1: boot recall of slot 0
      q.push_back({4'hF, row(0)});
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 busy after boot", 36'(busy), 36'(0));
      rd_chk("R1 initial slot", 1, 0);

      // R2 / R7 / R8: write byte, commit at stop, countdown
      issue(3'd1, 2, 1, 8'hA5);
      rd_chk("R7 slot before stop", 2, 1);
      chk("R7 busy before stop", 36'(busy), 36'(0));
      pulse_stop();
      m[2][1] = 8'hA5;
      chk("R7 busy after stop", 36'(busy), 36'(1));
      rd_chk("R2 written byte", 2, 1);
      repeat (3) @(negedge clk);
      chk("R8 busy holds without ticks", 36'(busy), 36'(1));
      for (int i = 1; i <= BT; i++) begin
         tick1();
         chk("R8 busy per tick", 36'(busy), 36'(i < BT));
      end

      // R3: store one wiper
      wiper = 32'h44_33_22_11;
      issue(3'd2, 1, 3, 8'h00);
      pulse_stop();
      m[1][3] = 8'h22;
      drain();
      rd_chk("R3 stored wiper", 1, 3);
      rd_chk("R3 other pot untouched", 0, 3);

      // R4: store all, wipers sampled at acceptance
      wiper = 32'hD4_C3_B2_A1;
      issue(3'd3, 0, 2, 8'h00);
      wiper = 32'h0F_0F_0F_0F;
      pulse_stop();
      m[0][2] = 8'hA1; m[1][2] = 8'hB2; m[2][2] = 8'hC3; m[3][2] = 8'hD4;
      drain();
      for (int p = 0; p < NP; p++) rd_chk("R4 store all lane", p, 2);

      // R5: recall one
      q.push_back({4'b0010, row(3)});
      issue(3'd4, 1, 3, 8'h00);
      @(negedge clk);
      // R6: recall all
      q.push_back({4'hF, row(2)});
      issue(3'd5, 0, 2, 8'h00);
      @(negedge clk);

      // R9: protect blocks stores
      wp_n = 1'b0;
      issue(3'd1, 0, 0, 8'h11);
      pulse_stop();
      chk("R9 busy stays low", 36'(busy), 36'(0));
      rd_chk("R9 slot unchanged", 0, 0);
      wp_n = 1'b1;

      // R10: rejection while pending and while busy
      issue(3'd1, 3, 0, 8'h77);
      issue(3'd5, 0, 0, 8'h00);
      @(negedge clk);
      pot_sel = 2'd3; slot_sel = 2'd0;
      pulse_stop();
      m[3][0] = 8'h77;
      issue(3'd1, 3, 1, 8'h99);
      pulse_stop();
      issue(3'd4, 3, 0, 8'h00);
      drain();
      chk("R10 busy done", 36'(busy), 36'(0));
      rd_chk("R10 rejected write", 3, 1);
      rd_chk("R10 accepted write", 3, 0);

      // R11: persistence across reset
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      q.push_back({4'hF, row(0)});
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      rd_chk("R11 kept after reset", 2, 1);
      rd_chk("R11 kept after reset", 3, 0);

      repeat (2) @(negedge clk);
      chk("R1/R5/R6 all strobes seen", 36'(q.size()), 36'(0));
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule